// File: doc/BRIEF.md
# Stall-Only Register Dependence Interlock

This block decides, every cycle, whether the instruction sitting in the decode stage of a five-stage in-order pipeline may move on to execute. The pipeline it serves has no bypass paths, so a source operand is only valid once its producer has reached write-back. The register file writes early in the cycle and reads late, so a value written in write-back can be read in decode in that same cycle.

The block compares each source register that the decode-stage instruction actually reads against the destinations of the two instructions directly ahead of it. The nearer one is in execute. The farther one is in memory. A producer counts only if it really writes a register and that register is not register 0.

On any match the block freezes the program counter and the IF/ID register, and zeroes the control fields entering ID/EX, which sends a bubble into execute. It is purely combinational apart from holding the run values during reset. A dependence on the immediately preceding instruction therefore costs two bubbles. A dependence on the instruction two places earlier costs one.

Top module: `hzd_stall_unit`

## Requirements
- R1: When a source flagged as read equals the nearer producer's destination, that producer's write enable is 1 and the destination is nonzero, `pc_we`=0 (stall).
- R2: The same match against the farther producer's destination and write enable also gives `pc_we`=0.
- R3: A source whose use flag is 0 never causes a stall, whatever its register number. Both `src_a` and `src_b` are checked only when their own flag is 1.
- R4: A producer destination of 0 never causes a stall.
- R5: A producer with write enable 0 never causes a stall. With no match of the kinds in R1 and R2, `pc_we`=1.
- R6: `ifid_we` always equals `pc_we`, and `bubble` is always its inverse.
- R7: While `rst_n`=0 the outputs hold `pc_we`=1, `ifid_we`=1, `bubble`=0, whatever the inputs are.
- R8: In a pipeline driven by the outputs, a consumer directly behind its producer stalls 2 cycles. A consumer two places behind stalls 1 cycle. A consumer three or more places behind stalls 0 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, used to sample the cycle checks |
| rst_n | input | 1 | Active-low reset; forces the run values |
| src_a | input | REG_AW | First source register of the decode-stage instruction |
| src_a_used | input | 1 | 1 when the decode instruction reads `src_a` |
| src_b | input | REG_AW | Second source register of the decode-stage instruction |
| src_b_used | input | 1 | 1 when the decode instruction reads `src_b` |
| near_dst | input | REG_AW | Destination of the instruction in execute |
| near_we | input | 1 | Register write enable of the instruction in execute |
| far_dst | input | REG_AW | Destination of the instruction in memory |
| far_we | input | 1 | Register write enable of the instruction in memory |
| pc_we | output | 1 | 1 lets the program counter advance |
| ifid_we | output | 1 | 1 lets the IF/ID register load |
| bubble | output | 1 | 1 zeroes the control entering ID/EX |

## Verification
The assertions check the per-cycle rules on every cycle. These are the equal write enables and the inverse bubble, the silence of unused sources, of register 0 and of non-writing producers, and the fact that a stall always has a matching source behind it. Whether the decision is right for every combination of register numbers and flags is shown by a sweep over a small register width, with the expected answer worked out in the bench. The stall counts that depend on distance (two, one and none) come from the freeze-and-bubble feedback over several cycles. Only the bench's pipeline scenarios can show them.

// File: rtl/hzd_pkg.sv
package hzd_pkg;

  localparam int MAX_AW = 8;
  typedef logic [MAX_AW-1:0] regnum_t;

  // A reader depends on a writer when it reads the register, the writer
  // really writes, and the register is not the hardwired zero.
  function automatic logic dep_hit(input logic    used,
                                   input regnum_t src,
                                   input logic    we,
                                   input regnum_t dst);
    return used && we && (dst != '0) && (dst == src);
  endfunction

endpackage

// File: rtl/hzd_src_cmp.sv
module hzd_src_cmp import hzd_pkg::*; #(
  parameter int REG_AW  = 5,
  parameter int NUM_PRD = 2
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [REG_AW-1:0]               src,
  input  logic                            used,
  input  logic [NUM_PRD-1:0][REG_AW-1:0]  dst,
  input  logic [NUM_PRD-1:0]              we,
  output logic [NUM_PRD-1:0]              hit
);

  localparam int PAD = MAX_AW - REG_AW;

  for (genvar p = 0; p < NUM_PRD; p++) begin : g_prd
    regnum_t src_x, dst_x;
    assign src_x = {{PAD{1'b0}}, src};
    assign dst_x = {{PAD{1'b0}}, dst[p]};
    assign hit[p] = dep_hit(used, src_x, we[p], dst_x);

    a_r4_zero_dst_silent: assert property (@(posedge clk) disable iff (!rst_n)
      (dst[p] == '0) |-> !hit[p]);
    a_r5_no_write_silent: assert property (@(posedge clk) disable iff (!rst_n)
      !we[p] |-> !hit[p]);
  end

  a_r3_unused_silent: assert property (@(posedge clk) disable iff (!rst_n)
    !used |-> (hit == '0));

endmodule

// File: rtl/hzd_ctl.sv
module hzd_ctl #(
  parameter int NUM_HIT = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_HIT-1:0] hits,
  output logic               pc_we,
  output logic               ifid_we,
  output logic               bubble
);

  logic freeze;

  assign freeze  = rst_n && (|hits);
  assign pc_we   = !freeze;
  assign ifid_we = !freeze;
  assign bubble  = freeze;

  a_r6_ifid_follows_pc: assert property (@(posedge clk) disable iff (!rst_n)
    ifid_we == pc_we);
  a_r6_bubble_inverse: assert property (@(posedge clk) disable iff (!rst_n)
    bubble != pc_we);

  always_comb begin
    if (!rst_n) begin
      a_r7_reset_runs: assert (pc_we && ifid_we && !bubble);
    end
  end

endmodule

// File: rtl/hzd_stall_unit.sv
module hzd_stall_unit #(
  parameter int REG_AW = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [REG_AW-1:0] src_a,
  input  logic              src_a_used,
  input  logic [REG_AW-1:0] src_b,
  input  logic              src_b_used,
  input  logic [REG_AW-1:0] near_dst,
  input  logic              near_we,
  input  logic [REG_AW-1:0] far_dst,
  input  logic              far_we,
  output logic              pc_we,
  output logic              ifid_we,
  output logic              bubble
);

  localparam int NUM_SRC = 2;
  localparam int NUM_PRD = 2;
  localparam int NUM_HIT = NUM_SRC * NUM_PRD;

  logic [NUM_SRC-1:0][REG_AW-1:0]  srcs;
  logic [NUM_SRC-1:0]              uses;
  logic [NUM_PRD-1:0][REG_AW-1:0]  dsts;
  logic [NUM_PRD-1:0]              wes;
  logic [NUM_SRC-1:0][NUM_PRD-1:0] src_hit;
  logic [NUM_HIT-1:0]              hits_flat;

  assign srcs = {src_b, src_a};
  assign uses = {src_b_used, src_a_used};
  assign dsts = {far_dst, near_dst};   // index 0 = nearer producer
  assign wes  = {far_we, near_we};

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    hzd_src_cmp #(.REG_AW(REG_AW), .NUM_PRD(NUM_PRD)) u_cmp (
      .clk  (clk),
      .rst_n(rst_n),
      .src  (srcs[s]),
      .used (uses[s]),
      .dst  (dsts),
      .we   (wes),
      .hit  (src_hit[s])
    );
  end

  assign hits_flat = src_hit;

  hzd_ctl #(.NUM_HIT(NUM_HIT)) u_ctl (
    .clk    (clk),
    .rst_n  (rst_n),
    .hits   (hits_flat),
    .pc_we  (pc_we),
    .ifid_we(ifid_we),
    .bubble (bubble)
  );

  // R1 / R2: a stall must be backed by some real source/producer match
  a_r1_stall_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    !pc_we |-> ((near_we && near_dst != '0 &&
                 ((src_a_used && src_a == near_dst) || (src_b_used && src_b == near_dst))) ||
                (far_we && far_dst != '0 &&
                 ((src_a_used && src_a == far_dst) || (src_b_used && src_b == far_dst)))));

  a_r2_far_match_stalls: assert property (@(posedge clk) disable iff (!rst_n)
    (far_we && far_dst != '0 && src_a_used && src_a == far_dst) |-> !pc_we);

endmodule

// File: tb/sim_hzd_stall_unit.sv
module sim_hzd_stall_unit;

  localparam int PERIOD = 10;
  localparam int AW     = 3;
  localparam int NREG   = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] src_a = '0, src_b = '0, near_dst = '0, far_dst = '0;
  logic          src_a_used = 1'b0, src_b_used = 1'b0, near_we = 1'b0, far_we = 1'b0;
  logic          pc_we, ifid_we, bubble;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  hzd_stall_unit #(.REG_AW(AW)) u0 (
    .clk(clk), .rst_n(rst_n),
    .src_a(src_a), .src_a_used(src_a_used),
    .src_b(src_b), .src_b_used(src_b_used),
    .near_dst(near_dst), .near_we(near_we),
    .far_dst(far_dst), .far_we(far_we),
    .pc_we(pc_we), .ifid_we(ifid_we), .bubble(bubble)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d (a=%0d/%0b b=%0d/%0b n=%0d/%0b f=%0d/%0b)",
               req, act, exp, src_a, src_a_used, src_b, src_b_used,
               near_dst, near_we, far_dst, far_we);
    end
  endtask

  // pipeline model: instruction table
  int t_dst[8], t_we[8], t_sa[8], t_ua[8], t_sb[8], t_ub[8];
  int t_n;

  task automatic run_seq(input string req, input int exp_stall[8]);
    int s_if, s_id, s_ex, s_mem, nxt;
    int stalls[8];
    for (int k = 0; k < 8; k++) stalls[k] = 0;
    s_if = 0; s_id = -1; s_ex = -1; s_mem = -1; nxt = 1;
    for (int cyc = 0; cyc < 40; cyc++) begin
      @(negedge clk);
      src_a_used = 1'b0; src_b_used = 1'b0; src_a = '0; src_b = '0;
      near_we = 1'b0; far_we = 1'b0; near_dst = '0; far_dst = '0;
      if (s_id >= 0) begin
        src_a = AW'(t_sa[s_id]); src_a_used = t_ua[s_id][0];
        src_b = AW'(t_sb[s_id]); src_b_used = t_ub[s_id][0];
      end
      if (s_ex >= 0)  begin near_dst = AW'(t_dst[s_ex]);  near_we = t_we[s_ex][0];  end
      if (s_mem >= 0) begin far_dst  = AW'(t_dst[s_mem]); far_we  = t_we[s_mem][0]; end
      #1;
      if (!pc_we) begin
        if (s_id >= 0) stalls[s_id]++;
        s_mem = s_ex; s_ex = -1;
      end else begin
        s_mem = s_ex; s_ex = s_id; s_id = s_if;
        if (nxt < t_n) begin s_if = nxt; nxt++; end else s_if = -1;
      end
    end
    for (int k = 0; k < t_n; k++) check(req, stalls[k], exp_stall[k]);
  endtask

  function automatic bit hit_f(int s, int u, int d, int w);
    return (u != 0) && (w != 0) && (d != 0) && (d == s);
  endfunction

  initial begin
    int exp_s[8];
    // R7: reset with colliding inputs
    src_a = 3'd5; src_a_used = 1'b1; near_dst = 3'd5; near_we = 1'b1;
    #2;
    check("R7 pc_we", pc_we, 1);
    check("R7 ifid_we", ifid_we, 1);
    check("R7 bubble", bubble, 0);
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;

    // sweep all operand combinations: R1 R2 R3 R4 R5 R6
    for (int v = 0; v < (1 << (4*AW + 4)); v++) begin
      int a, b, n, f, ua, ub, wn, wf, eh;
      string lbl;
      @(negedge clk);
      a  = v % NREG;            b  = (v / NREG) % NREG;
      n  = (v / (NREG*NREG)) % NREG;
      f  = (v / (NREG*NREG*NREG)) % NREG;
      ua = (v >> (4*AW)) & 1;   ub = (v >> (4*AW+1)) & 1;
      wn = (v >> (4*AW+2)) & 1; wf = (v >> (4*AW+3)) & 1;
      src_a = AW'(a); src_b = AW'(b); near_dst = AW'(n); far_dst = AW'(f);
      src_a_used = ua[0]; src_b_used = ub[0]; near_we = wn[0]; far_we = wf[0];
      #1;
      eh = int'(hit_f(a, ua, n, wn) || hit_f(b, ub, n, wn) ||
                hit_f(a, ua, f, wf) || hit_f(b, ub, f, wf));
      if (hit_f(a, ua, n, wn) || hit_f(b, ub, n, wn)) lbl = "R1";
      else if (eh != 0) lbl = "R2";
      else if ((ua == 0 && (a == n || a == f)) || (ub == 0 && (b == n || b == f))) lbl = "R3";
      else if ((a == 0 || b == 0) && (n == 0 || f == 0)) lbl = "R4";
      else lbl = "R5";
      check(lbl, pc_we, 1 - eh);
      if (ifid_we != pc_we || bubble == pc_we) check("R6", 0, 1);
    end

    // R8: dependences at distance 1, 2, 1 through the pipeline
    t_n = 5;
    t_dst = '{5,3,2,3,0,0,0,0}; t_we = '{1,1,1,1,0,0,0,0};
    t_sa  = '{2,5,2,5,5,0,0,0}; t_ua = '{1,1,1,1,1,0,0,0};
    t_sb  = '{1,0,0,3,3,0,0,0}; t_ub = '{1,0,0,1,1,0,0,0};
    exp_s = '{0,2,0,1,2,0,0,0};
    run_seq("R8 distances", exp_s);

    // R8: distance 3 needs nothing (write early, read late); R4 r0 writer
    t_n = 5;
    t_dst = '{4,0,6,1,0,0,0,0}; t_we = '{1,1,1,1,0,0,0,0};
    t_sa  = '{1,1,2,4,0,0,0,0}; t_ua = '{1,1,1,1,1,0,0,0};
    t_sb  = '{0,0,0,0,0,0,0,0}; t_ub = '{0,0,0,0,1,0,0,0};
    exp_s = '{0,0,0,0,0,0,0,0};
    run_seq("R8 far and zero", exp_s);

    // R3: rt not read by a load behind a writer of that number
    t_n = 2;
    t_dst = '{6,2,0,0,0,0,0,0}; t_we = '{1,1,0,0,0,0,0,0};
    t_sa  = '{1,3,0,0,0,0,0,0}; t_ua = '{1,1,0,0,0,0,0,0};
    t_sb  = '{0,6,0,0,0,0,0,0}; t_ub = '{0,0,0,0,0,0,0,0};
    exp_s = '{0,0,0,0,0,0,0,0};
    run_seq("R3 unread operand", exp_s);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(PERIOD * 150000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule